// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit runs one integer operation on a 64-bit word that it treats as a set of equal, independent lanes. A size select splits the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The operations are add and subtract (wrapping or clamped), three bitwise operations, per-lane shifts, compares that return lane masks, and a narrowing pack that clamps.

Each accepted operation takes the two operands, an opcode, the lane size, a clamp enable and a signed/unsigned select. The unit returns a registered result one clock later with an output strobe. The result register keeps its value for as long as no new operation is accepted. Compare masks can drive later bitwise selects without any branch. Pack turns wide intermediate values back into narrow pixel or sample data.

Top module: `simd_alu`

## Requirements
- R1: Opcode 0 adds and opcode 1 subtracts (A minus B), lane by lane, and wraps when `sat` is 0. Size 0 gives 8-bit lanes, size 1 gives 16-bit lanes, and sizes 2 and 3 give 32-bit lanes. No carry or borrow ever moves from one lane into the next.
- R2: When `sat` is 1 and `sgn` is 0, add and subtract clamp each lane to the range 0 to 2^w−1, where w is the lane width.
- R3: When `sat` is 1 and `sgn` is 1, add and subtract clamp each lane to the range −2^(w−1) to 2^(w−1)−1.
- R4: Opcode 7 (equal) and opcode 8 (greater than, A > B) set each lane to all ones when the test is true and to all zeros when it is false. Greater than compares signed when `sgn` is 1 and unsigned when `sgn` is 0.
- R5: Opcode 5 shifts each lane of A left, filling with zeros. Opcode 6 shifts each lane of A right, filling with copies of the sign bit. The shift count is the same lane of B, read as unsigned. A count equal to or larger than w gives all zeros for the left shift and the sign bit in every position for the right shift.
- R6: Opcode 2 gives (NOT A) AND B, opcode 3 gives A OR B, and opcode 4 gives A XOR B. For these three the size, `sat` and `sgn` inputs have no effect.
- R7: Opcode 9 (pack) narrows 16-bit source lanes to 8 bits when size is 1, and 32-bit lanes to 16 bits when size is 2 or 3. The narrowed lanes of A fill the low half of the result in lane order, and those of B fill the high half. Any value out of range is clamped: to the signed range of the narrow lane when `sgn` is 1 (source read as signed), or to 0 to all-ones when `sgn` is 0 (source read as unsigned). With size 0, pack returns zero.
- R8: One clock edge after `in_valid` is high, `result` holds the value for the inputs sampled at that edge, and `out_valid` is high for that one cycle.
- R9: Reset clears `result` and `out_valid`. In a cycle where `in_valid` is low, `result` keeps its value and `out_valid` falls.
- R10: Opcodes 10 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted on this edge |
| op | input | 4 | Opcode |
| size | input | 2 | Lane size select: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| sat | input | 1 | Clamp enable for add and subtract |
| sgn | input | 1 | Signed interpretation select |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit with the default 64-bit word. At that width there are eight, four or two lanes, so the top and bottom lane of every size can be hit with vectors that are written by hand and checked by eye. Lanes that sit at the limit next to their neighbours show whether a carry leaks across a lane edge. The two pack halves show whether A and B end up in the right places. Counts of w and more, and values one step past each clamp limit, can all be reached at every lane size.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ANDN = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SRA  = 4'd6,
    OP_CEQ  = 4'd7,
    OP_CGT  = 4'd8,
    OP_PACK = 4'd9
  } op_e;

  localparam int NUM_SIZES = 3;
  localparam int MIN_LANE  = 8;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 8
) (
  input  simd_pkg::op_e  op,
  input  logic           sat,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   r
);
  import simd_pkg::*;

  localparam int XW = W + 2;
  localparam logic [W-1:0] LIM = W'(W);

  // widen by two bits so that one extra bit can carry the sign and one the overflow
  function automatic logic [XW-1:0] widen(input logic [W-1:0] v, input logic s);
    return {{2{s & v[W-1]}}, v};
  endfunction

  function automatic logic [W-1:0] clamp(input logic [XW-1:0] v, input logic s,
                                         input logic en);
    if (!en) return v[W-1:0];
    if (s) begin
      if (v[XW-1:W-1] == {3{v[XW-1]}}) return v[W-1:0];
      return v[XW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end
    if (v[XW-1:W] == 2'b00) return v[W-1:0];
    return v[XW-1] ? '0 : '1;
  endfunction

  function automatic logic [W-1:0] shl(input logic [W-1:0] v, input logic [W-1:0] c);
    if (c >= LIM) return '0;
    return v << c;
  endfunction

  function automatic logic [W-1:0] sra(input logic [W-1:0] v, input logic [W-1:0] c);
    if (c >= LIM) return {W{v[W-1]}};
    return W'($signed(v) >>> c);
  endfunction

  logic [XW-1:0] ax, bx, sum_x, dif_x;
  logic          lane_eq, lane_gt;

  assign ax      = widen(a, sgn);
  assign bx      = widen(b, sgn);
  assign sum_x   = ax + bx;
  assign dif_x   = ax - bx;
  assign lane_eq = (a == b);
  assign lane_gt = sgn ? ($signed(a) > $signed(b)) : (a > b);

  always_comb begin
    case (op)
      OP_ADD:  r = clamp(sum_x, sgn, sat);
      OP_SUB:  r = clamp(dif_x, sgn, sat);
      OP_SHL:  r = shl(a, b);
      OP_SRA:  r = sra(a, b);
      OP_CEQ:  r = {W{lane_eq}};
      OP_CGT:  r = {W{lane_gt}};
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/simd_narrow.sv
module simd_narrow #(
  parameter int SW = 16
) (
  input  logic [SW-1:0]   v,
  input  logic            sgn,
  output logic [SW/2-1:0] n
);
  localparam int DW = SW / 2;

  logic fits_s, fits_u;

  assign fits_s = (v[SW-1:DW-1] == {(DW+1){v[SW-1]}});
  assign fits_u = (v[SW-1:DW] == '0);

  always_comb begin
    if (sgn) begin
      if (fits_s)         n = v[DW-1:0];
      else if (v[SW-1])   n = {1'b1, {(DW-1){1'b0}}};
      else                n = {1'b0, {(DW-1){1'b1}}};
    end else begin
      n = fits_u ? v[DW-1:0] : '1;
    end
  end
endmodule

// File: rtl/simd_pack.sv
module simd_pack #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [DATA_W-1:0] r
);
  localparam int HALF = DATA_W / 2;
  localparam int N16  = DATA_W / 16;
  localparam int N32  = DATA_W / 32;

  logic [HALF-1:0] na8, nb8, na16, nb16;

  for (genvar i = 0; i < N16; i++) begin : g_h2b
    simd_narrow #(.SW(16)) u_na (.v(a[i*16 +: 16]), .sgn(sgn), .n(na8[i*8 +: 8]));
    simd_narrow #(.SW(16)) u_nb (.v(b[i*16 +: 16]), .sgn(sgn), .n(nb8[i*8 +: 8]));
  end

  for (genvar i = 0; i < N32; i++) begin : g_w2h
    simd_narrow #(.SW(32)) u_na (.v(a[i*32 +: 32]), .sgn(sgn), .n(na16[i*16 +: 16]));
    simd_narrow #(.SW(32)) u_nb (.v(b[i*32 +: 32]), .sgn(sgn), .n(nb16[i*16 +: 16]));
  end

  always_comb begin
    if (size == 2'd1)  r = {nb8, na8};
    else if (size[1])  r = {nb16, na16};
    else               r = '0;
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [1:0]        size,
  input  logic              sat,
  input  logic              sgn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  import simd_pkg::*;

  op_e                                   opc;
  logic [NUM_SIZES-1:0][DATA_W-1:0]      lane_res;
  logic [DATA_W-1:0]                     lane_sel;
  logic [DATA_W-1:0]                     pack_res;
  logic [DATA_W-1:0]                     next_res;

  assign opc = op_e'(op);

  // one full set of lanes per lane width
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
    localparam int LW = MIN_LANE << k;
    for (genvar g = 0; g < DATA_W / LW; g++) begin : g_ln
      simd_lane #(.W(LW)) u_lane (
        .op  (opc),
        .sat (sat),
        .sgn (sgn),
        .a   (a[g*LW +: LW]),
        .b   (b[g*LW +: LW]),
        .r   (lane_res[k][g*LW +: LW])
      );
    end
  end

  always_comb begin
    case (size)
      2'd0:    lane_sel = lane_res[0];
      2'd1:    lane_sel = lane_res[1];
      default: lane_sel = lane_res[2];
    endcase
  end

  simd_pack #(.DATA_W(DATA_W)) u_pack (
    .a    (a),
    .b    (b),
    .size (size),
    .sgn  (sgn),
    .r    (pack_res)
  );

  always_comb begin
    case (opc)
      OP_ADD, OP_SUB, OP_SHL, OP_SRA, OP_CEQ, OP_CGT: next_res = lane_sel;
      OP_ANDN: next_res = ~a & b;
      OP_OR:   next_res = a | b;
      OP_XOR:  next_res = a ^ b;
      OP_PACK: next_res = pack_res;
      default: next_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        op,
  input logic [1:0]        size,
  input logic              sat,
  input logic              sgn,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  localparam int NB = DATA_W / 8;

  // R8: strobe follows an accepted operation
  a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9: idle cycle holds result and drops strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && !out_valid));

  // R6: xor lands unchanged
  a_r6_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd4) |=> (result == $past(a ^ b)));

  // R10: undefined opcodes give zero
  a_r10_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd10) |=> (result == '0));

  // R7: unsigned pack of zero A leaves low half zero
  a_r7_pack_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd9 && !sgn && size != 2'd0 && a == '0)
      |=> (result[DATA_W/2-1:0] == '0));

  for (genvar g = 0; g < NB; g++) begin : g_byte
    // R4: every byte of a compare result is a full mask
    a_r4_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op == 4'd7 || op == 4'd8))
        |=> (result[g*8 +: 8] == 8'h00 || result[g*8 +: 8] == 8'hFF));

    // R2: unsigned clamped add never falls below operand A
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd0 && size == 2'd0 && sat && !sgn)
        |=> (result[g*8 +: 8] >= $past(a[g*8 +: 8])));
  end
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;
  localparam int DW = 64;
  localparam int NV = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [3:0]    op = '0;
  logic [1:0]    size = '0;
  logic          sat = 1'b0;
  logic          sgn = 1'b0;
  logic [DW-1:0] a = '0;
  logic [DW-1:0] b = '0;
  logic          out_valid;
  logic [DW-1:0] result;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  simd_alu #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .sat(sat), .sgn(sgn), .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  // {req, op, size, sat, sgn, a, b, expected}
  localparam logic [207:0] VEC [NV] = '{
    {8'd1, 4'd0, 2'd0, 1'b0, 1'b0, 64'h01FF_0000_0000_0080, 64'h0101_0000_0000_0080, 64'h0200_0000_0000_0000}, // R1
    {8'd1, 4'd0, 2'd1, 1'b0, 1'b0, 64'h0000_FFFF_0000_0001, 64'h0000_0001_0000_0001, 64'h0000_0000_0000_0002}, // R1
    {8'd1, 4'd0, 2'd2, 1'b0, 1'b0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000}, // R1
    {8'd1, 4'd1, 2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF}, // R1
    {8'd1, 4'd1, 2'd1, 1'b0, 1'b0, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_0001_FFFF}, // R1
    {8'd1, 4'd0, 2'd3, 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000}, // R1
    {8'd2, 4'd0, 2'd0, 1'b1, 1'b0, 64'hFF10_0000_0000_00F0, 64'h0110_0000_0000_0020, 64'hFF20_0000_0000_00FF}, // R2
    {8'd2, 4'd1, 2'd1, 1'b1, 1'b0, 64'h0005_0010_0000_1234, 64'h0006_0001_0001_0234, 64'h0000_000F_0000_1000}, // R2
    {8'd3, 4'd0, 2'd0, 1'b1, 1'b1, 64'h7F80_0000_0000_0001, 64'h0180_0000_0000_00FF, 64'h7F80_0000_0000_0000}, // R3
    {8'd3, 4'd1, 2'd2, 1'b1, 1'b1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 64'h8000_0000_7FFF_FFFF}, // R3
    {8'd3, 4'd0, 2'd1, 1'b1, 1'b1, 64'h7FF0_8000_0003_0000, 64'h0020_FFFF_FFFE_0000, 64'h7FFF_8000_0001_0000}, // R3
    {8'd4, 4'd7, 2'd0, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00}, // R4
    {8'd4, 4'd8, 2'd1, 1'b0, 1'b1, 64'h0001_8000_7FFF_0005, 64'h0000_0001_8000_0005, 64'hFFFF_0000_FFFF_0000}, // R4
    {8'd4, 4'd8, 2'd1, 1'b0, 1'b0, 64'h0001_8000_7FFF_0005, 64'h0000_0001_8000_0005, 64'hFFFF_FFFF_0000_0000}, // R4
    {8'd4, 4'd7, 2'd2, 1'b0, 1'b0, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0000, 64'hFFFF_FFFF_0000_0000}, // R4
    {8'd5, 4'd5, 2'd0, 1'b0, 1'b0, 64'h0101_0101_0101_0101, 64'h0001_0708_09FF_0302, 64'h0102_8000_0000_0804}, // R5
    {8'd5, 4'd6, 2'd1, 1'b0, 1'b0, 64'h8000_8000_7FFF_F0F0, 64'h0004_0010_0001_0020, 64'hF800_FFFF_3FFF_FFFF}, // R5
    {8'd5, 4'd5, 2'd2, 1'b0, 1'b0, 64'h0000_0001_8000_0001, 64'h0000_001F_0000_0020, 64'h8000_0000_0000_0000}, // R5
    {8'd5, 4'd6, 2'd0, 1'b0, 1'b0, 64'h8040_0000_0000_007F, 64'h0701_0000_0000_0008, 64'hFF20_0000_0000_0000}, // R5
    {8'd6, 4'd2, 2'd0, 1'b1, 1'b1, 64'hFF00_FF00_F0F0_0000, 64'h0FF0_0FF0_FFFF_1234, 64'h00F0_00F0_0F0F_1234}, // R6
    {8'd6, 4'd3, 2'd1, 1'b1, 1'b0, 64'hF000_0000_0000_000F, 64'h0F00_0000_0000_00F0, 64'hFF00_0000_0000_00FF}, // R6
    {8'd6, 4'd4, 2'd2, 1'b0, 1'b1, 64'hAAAA_5555_FFFF_0000, 64'hFFFF_5555_0000_0000, 64'h5555_0000_FFFF_0000}, // R6
    {8'd7, 4'd9, 2'd1, 1'b0, 1'b1, 64'h0080_FF7F_0012_FFFE, 64'h0000_0001_7FFF_8000, 64'h0001_7F80_7F80_12FE}, // R7
    {8'd7, 4'd9, 2'd1, 1'b0, 1'b0, 64'h0100_00FF_0000_FFFF, 64'h0012_0034_0056_0078, 64'h1234_5678_FFFF_00FF}, // R7
    {8'd7, 4'd9, 2'd2, 1'b0, 1'b1, 64'h0001_0000_FFFF_7FFF, 64'h0000_1234_FFFF_FFFF, 64'h1234_FFFF_7FFF_8000}, // R7
    {8'd7, 4'd9, 2'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}, // R7
    {8'd10, 4'd15, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000} // R10
  };

  task automatic check(input int req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(9, result, '0);
    check(9, {63'd0, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {op, size, sat, sgn, a, b} = VEC[i][199:64];
      in_valid = 1'b1;
      @(negedge clk);
      check(int'(VEC[i][207:200]), result, VEC[i][63:0]);
      check(8, {63'd0, out_valid}, 64'd1); // R8
      in_valid = 1'b0;
    end

    // R9: idle cycle with new operands keeps the last result
    held = result;
    op = 4'd4; a = 64'h0123_4567_89AB_CDEF; b = '1;
    @(negedge clk);
    check(9, result, held);
    check(9, {63'd0, out_valid}, '0);

    // R8: back-to-back operations each land one edge later
    in_valid = 1'b1; op = 4'd3; size = 2'd0; a = 64'hF0; b = 64'h0F;
    @(negedge clk);
    check(8, result, 64'hFF);
    op = 4'd0; sat = 1'b0; a = 64'h7F; b = 64'h01;
    @(negedge clk);
    check(8, result, 64'h80);
    in_valid = 1'b0;
    @(negedge clk);
    check(8, {63'd0, out_valid}, '0);

    // R9: reset mid-run clears result
    rst_n = 1'b0;
    @(negedge clk);
    check(9, result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
  end
endmodule